// File: doc/BRIEF.md
# Dual-Clock FIFO with Combined Status Flags

This block is a first-in first-out buffer built on a two-port RAM. A producer pushes words on its own clock and a consumer pops them on a second clock. The two clocks may be the same net or unrelated. Each side has its own binary pointer with one extra wrap bit. Each pointer is passed to the other side as Gray code through a two-stage synchronizer, so the flags need no external logic.

Three status outputs are provided. `empty_full` is a single line that is high when the buffer is either empty or full. `half_full` is high once half the storage is occupied. `almost_flag` is high when occupancy is near either end of the range, and a run-time offset input sets how near. A parameter chooses whether the read data leaves straight from the RAM output register or through one extra pipeline register. A parameter for each port can invert that port's clock, so the port works on the falling edge of its input clock.

Top module: `fifo_dual_clk`

## Requirements
- R1: On an active write-clock edge with `wr_en` high and the buffer not full, `wr_data` is stored and the write pointer advances by one.
- R2: On an active read-clock edge with `rd_en` high and the buffer not empty, the oldest word is removed. Words leave in the order they were written. With `OUT_REG`=0 the word appears on `rd_data` after that edge. With `OUT_REG`=1 it appears one read-clock edge later.
- R3: `empty_full` is 1 when the read side sees no unread word, or when the write side sees `DEPTH` words stored. Otherwise it is 0.
- R4: A write attempted while full is dropped. The stored contents and their order are unchanged.
- R5: A read attempted while empty is dropped. `rd_data` keeps its previous value.
- R6: `half_full` is 1 exactly when the occupancy seen by the read side is at least `DEPTH`/2.
- R7: `almost_flag` is 1 exactly when that occupancy is at most N or at least `DEPTH`-N, where N is the value on `almost_offset`. It follows a change of `almost_offset` within the same cycle.
- R8: A synchronous active-high `rst`, held for at least three edges of each clock, empties the buffer. After it, `empty_full`=1, `half_full`=0 and `rd_data`=0.
- R9: With `WR_CLK_INV`/`RD_CLK_INV` set to 1, the port acts on the falling edge of its clock input and otherwise behaves the same.
- R10: Pointers cross between the clock domains as Gray code through two flip-flops. The flags on the other side reflect an operation within three edges of that side's clock, and the read-side occupancy never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| wr_en | input | 1 | Push request |
| wr_data | input | DW | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | DW | Popped word |
| almost_offset | input | AW+1 | Distance N from either end for `almost_flag` |
| empty_full | output | 1 | High when empty or full |
| half_full | output | 1 | High at or above half occupancy |
| almost_flag | output | 1 | High when within N of empty or of full |

## Verification
A table of push bursts and pop bursts walks the occupancy from zero to full, past full, and back to zero past empty. The flags are checked at the points where each one should change. Those points separate the half threshold and both sides of the almost window, and show whether the combined flag is high for the right reason at each end.

The pops past empty and the pushes past full show that dropped requests move neither pointer: the popped sequence keeps its order, with no gaps and no stray data. A second instance with the extra output stage and inverted clocks is driven on the complementary clock. Its data, one edge behind, separates the two output modes and confirms the edge choice.

Directed steps then vary the offset at a fixed occupancy and apply reset while the buffer holds data.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    // Status bundle produced by the read-side controller
    typedef struct packed {
        logic empty;
        logic half;
        logic almost;
    } rd_stat_t;

    // Binary to reflected Gray code
    function automatic logic [31:0] b2g(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code to binary (prefix XOR from the top bit down)
    function automatic logic [31:0] g2b(input logic [31:0] g);
        logic [31:0] r;
        r = g;
        for (int s = 1; s < 32; s = s * 2) begin
            r = r ^ (r >> s);
        end
        return r;
    endfunction

endpackage

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
    parameter int AW      = 4,
    parameter int DW      = 8,
    parameter bit OUT_REG = 1'b0
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // q changes only when a pop is accepted, so a dropped pop leaves it alone
    always_ff @(posedge rclk) begin
        if (rst) begin
            q <= '0;
        end else if (re) begin
            q <= mem[raddr];
        end
    end

    generate
        if (OUT_REG) begin : g_outreg
            logic [DW-1:0] q_pipe;
            always_ff @(posedge rclk) begin
                if (rst) begin
                    q_pipe <= '0;
                end else begin
                    q_pipe <= q;
                end
            end
            assign rdata = q_pipe;
        end else begin : g_direct
            assign rdata = q;
        end
    endgenerate

endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW:0]   rd_gray_async,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wr_gray,
    output logic          full
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin, wbin_nx, rg_s1, rg_s2, full_pat;

    always_comb begin
        // Full: Gray pointers differ in the two top bits only
        full_pat = {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]};
        full     = (wr_gray == full_pat);
        we       = wr_en && !full;
        wbin_nx  = wbin + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin    <= '0;
            wr_gray <= '0;
            rg_s1   <= '0;
            rg_s2   <= '0;
        end else begin
            rg_s1 <= rd_gray_async;
            rg_s2 <= rg_s1;
            if (we) begin
                wbin    <= wbin_nx;
                wr_gray <= PW'(b2g(32'(wbin_nx)));
            end
        end
    end

    assign waddr = wbin[AW-1:0];

    // R1
    wr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full) |=> (wbin == $past(wbin) + PW'(1)));

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(wbin));

endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW:0]   wr_gray_async,
    input  logic [AW:0]   offset,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rd_gray,
    output rd_stat_t      stat
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] rbin, rbin_nx, wg_s1, wg_s2, ws_bin, occ;
    int            occ_i, off_i;

    always_comb begin
        ws_bin      = PW'(g2b(32'(wg_s2)));
        occ         = ws_bin - rbin;
        occ_i       = int'(occ);
        off_i       = int'(offset);
        stat.empty  = (rd_gray == wg_s2);
        stat.half   = (occ_i >= DEPTH / 2);
        stat.almost = (occ_i <= off_i) || (occ_i >= DEPTH - off_i);
        re          = rd_en && !stat.empty;
        rbin_nx     = rbin + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin    <= '0;
            rd_gray <= '0;
            wg_s1   <= '0;
            wg_s2   <= '0;
        end else begin
            wg_s1 <= wr_gray_async;
            wg_s2 <= wg_s1;
            if (re) begin
                rbin    <= rbin_nx;
                rd_gray <= PW'(b2g(32'(rbin_nx)));
            end
        end
    end

    assign raddr = rbin[AW-1:0];

    // R2
    rd_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !stat.empty) |=> (rbin == $past(rbin) + PW'(1)));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && stat.empty) |=> $stable(rbin));

    // R3
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stat.empty |-> (occ_i == 0));

    // R10
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ_i <= DEPTH);

endmodule

// File: rtl/fifo_dual_clk.sv
module fifo_dual_clk
    import dcfifo_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int DW         = 8,
    parameter bit OUT_REG    = 1'b0,
    parameter bit WR_CLK_INV = 1'b0,
    parameter bit RD_CLK_INV = 1'b0,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic [AW:0]   almost_offset,
    output logic          empty_full,
    output logic          half_full,
    output logic          almost_flag
);
    logic          wclk, rclk;
    logic          we, re, full;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wr_gray, rd_gray;
    rd_stat_t      stat;

    generate
        if (WR_CLK_INV) begin : g_wclk_inv
            assign wclk = ~wr_clk;
        end else begin : g_wclk_true
            assign wclk = wr_clk;
        end
        if (RD_CLK_INV) begin : g_rclk_inv
            assign rclk = ~rd_clk;
        end else begin : g_rclk_true
            assign rclk = rd_clk;
        end
    endgenerate

    dcfifo_wr_ctl #(.AW(AW)) u_wr (
        .clk           (wclk),
        .rst           (rst),
        .wr_en         (wr_en),
        .rd_gray_async (rd_gray),
        .we            (we),
        .waddr         (waddr),
        .wr_gray       (wr_gray),
        .full          (full)
    );

    dcfifo_rd_ctl #(.AW(AW)) u_rd (
        .clk           (rclk),
        .rst           (rst),
        .rd_en         (rd_en),
        .wr_gray_async (wr_gray),
        .offset        (almost_offset),
        .re            (re),
        .raddr         (raddr),
        .rd_gray       (rd_gray),
        .stat          (stat)
    );

    dcfifo_ram #(.AW(AW), .DW(DW), .OUT_REG(OUT_REG)) u_ram (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .rclk  (rclk),
        .rst   (rst),
        .re    (re),
        .raddr (raddr),
        .rdata (rd_data)
    );

    assign empty_full  = stat.empty | full;
    assign half_full   = stat.half;
    assign almost_flag = stat.almost;

endmodule

// File: tb/tb_fifo_dual_clk.sv
module tb_fifo_dual_clk;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          clk_n;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW:0]   offs = 5'd3;
    logic [DW-1:0] rd_data_a, rd_data_b;
    logic          ef_a, hf_a, al_a, ef_b, hf_b, al_b;

    always #10 clk = ~clk;  // 50 MHz
    assign clk_n = ~clk;

    fifo_dual_clk #(.DEPTH(DEPTH), .DW(DW)) dut (
        .wr_clk(clk), .rd_clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data_a), .almost_offset(offs),
        .empty_full(ef_a), .half_full(hf_a), .almost_flag(al_a));

    // R9: registered output, both ports on the falling edge of clk_n
    fifo_dual_clk #(.DEPTH(DEPTH), .DW(DW), .OUT_REG(1'b1),
                    .WR_CLK_INV(1'b1), .RD_CLK_INV(1'b1)) dut_reg (
        .wr_clk(clk_n), .rd_clk(clk_n), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data_b), .almost_offset(offs),
        .empty_full(ef_b), .half_full(hf_b), .almost_flag(al_b));

    int total = 0, fails = 0;
    bit done = 1'b0;

    // reference model
    logic [DW-1:0] mq [64];
    int head = 0, tail = 0, cnt = 0;
    logic [DW-1:0] next_val = 8'h10;
    logic [DW-1:0] d0_exp = '0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic flags(input string req, input bit ef, input bit hf, input bit al);
        check({req, " empty_full"}, int'(ef_a), int'(ef));
        check({req, " half_full"}, int'(hf_a), int'(hf));
        check({req, " almost"}, int'(al_a), int'(al));
        check({req, " empty_full reg"}, int'(ef_b), int'(ef));
        check({req, " half_full reg"}, int'(hf_b), int'(hf));
        check({req, " almost reg"}, int'(al_b), int'(al));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_data = next_val;
            if (cnt < DEPTH) begin
                mq[tail] = next_val;
                tail = (tail + 1) % 64;
                cnt++;
            end
            next_val = next_val + 8'd1;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop(input int n);
        logic [DW-1:0] nxt;
        bit acc;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R2 R5 rd_data", int'(rd_data_a), int'(nxt));
                check("R2 rd_data registered", int'(rd_data_b), int'(d0_exp));
                d0_exp = nxt;
            end
            rd_en = 1'b1;
            acc = (cnt > 0);
            nxt = d0_exp;
            if (acc) begin
                nxt = mq[head];
                head = (head + 1) % 64;
                cnt--;
            end
        end
        @(negedge clk);
        rd_en = 1'b0;
        check("R2 R5 rd_data", int'(rd_data_a), int'(nxt));
        check("R2 rd_data registered", int'(rd_data_b), int'(d0_exp));
        d0_exp = nxt;
        @(negedge clk);
        check("R2 rd_data registered last", int'(rd_data_b), int'(d0_exp));
    endtask

    // {is_pop, count[4:0], exp_empty_full, exp_half, exp_almost}; offset N=3
    localparam logic [8:0] VEC [13] = '{
        {1'b0, 5'd1, 3'b001},   // occ 1
        {1'b0, 5'd2, 3'b001},   // occ 3  (R7 low edge)
        {1'b0, 5'd1, 3'b000},   // occ 4
        {1'b0, 5'd4, 3'b010},   // occ 8  (R6 threshold)
        {1'b0, 5'd4, 3'b010},   // occ 12
        {1'b0, 5'd1, 3'b011},   // occ 13 (R7 high edge)
        {1'b0, 5'd3, 3'b111},   // occ 16 full
        {1'b0, 5'd2, 3'b111},   // R4 overflow dropped
        {1'b1, 5'd3, 3'b011},   // occ 13
        {1'b1, 5'd6, 3'b000},   // occ 7
        {1'b1, 5'd4, 3'b001},   // occ 3
        {1'b1, 5'd3, 3'b101},   // occ 0 empty
        {1'b1, 5'd2, 3'b101}    // R5 underflow dropped
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        flags("R8 reset", 1'b1, 1'b0, 1'b1);
        check("R8 rd_data reset", int'(rd_data_a), 0);

        for (int v = 0; v < 13; v++) begin
            if (VEC[v][8]) pop(int'(VEC[v][7:3]));
            else           push(int'(VEC[v][7:3]));
            settle();
            // R1 R3 R6 R7 R10 flags after each burst
            flags($sformatf("R3 R6 R7 R10 step%0d", v), VEC[v][2], VEC[v][1], VEC[v][0]);
        end
        check("R4 R5 model drained", cnt, 0);

        // R7 offset changes at fixed occupancy 5
        push(5);
        settle();
        flags("R7 occ5 N3", 1'b0, 1'b0, 1'b0);
        offs = 5'd5; @(negedge clk);
        flags("R7 occ5 N5", 1'b0, 1'b0, 1'b1);
        offs = 5'd4; @(negedge clk);
        flags("R7 occ5 N4", 1'b0, 1'b0, 1'b0);
        offs = 5'd11; @(negedge clk);
        flags("R7 occ5 N11", 1'b0, 1'b0, 1'b1);
        offs = 5'd4;

        // R8 reset with content
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        head = 0; tail = 0; cnt = 0; d0_exp = '0;
        @(negedge clk);
        flags("R8 reset with data", 1'b1, 1'b0, 1'b1);
        check("R8 rd_data cleared", int'(rd_data_a), 0);
        check("R8 rd_data reg cleared", int'(rd_data_b), 0);

        // R1 R2 pointers restart cleanly
        push(1);
        settle();
        flags("R1 one word", 1'b0, 1'b0, 1'b1);
        pop(1);
        settle();
        flags("R2 drained", 1'b1, 1'b0, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule